// File: doc/BRIEF.md
# Tuner PLL Tuning-Word Receiver

This block is a write-only I2C slave that feeds a tuner PLL controller. A system clock samples SCL and SDA, which pass through synchronizers first. The block detects START and STOP conditions and compares the address byte with a write address chosen by two strap inputs. It acknowledges an accepted byte by pulling SDA low during the ninth clock.

After the address byte, data bytes are taken two at a time. The top bit of the first byte of each pair selects the destination register:
- When that bit is 0, the pair is a frequency word. The low seven bits of the first byte give the upper divider bits and the second byte gives the lower eight bits. A single-cycle strobe marks each new frequency word.
- When that bit is 1, the first byte is a control byte. The low nibble of the second byte holds the band-switch bits.

A pair is applied only after its second byte has fully arrived. Bytes beyond the fourth are neither acknowledged nor used.

Top module: `tune_word_rx`

## Requirements
- R1: After reset, `freq_word` is 256 (parameter `FREQ_RST`), `ctrl_byte` is 0x80, `band_bits` is 0, and both `sda_pull` and `freq_stb` are low.
- R2: The only address byte accepted is {5'b11000, addr_sel[1], addr_sel[0], 1'b0}, giving 0xC0/0xC2/0xC4/0xC6. Any other address gets no acknowledge, and the data bytes that follow it change no register.
- R3: The block pulls `sda_pull` high (SDA low) through the ninth clock of a matched address byte and of each of the first four data bytes. It releases SDA at the falling SCL that ends that clock.
- R4: If bit 7 of data byte 0 or 2 is 0, that byte and the next one form a frequency word: `freq_word` = {first[6:0], second[7:0]}. `freq_stb` pulses high for exactly one cycle for each such word, and `freq_word` changes only in that cycle.
- R5: If bit 7 of data byte 0 or 2 is 1, that byte is loaded into `ctrl_byte` and bits [3:0] of the following byte are loaded into `band_bits`. Bits [7:4] of the band byte are ignored, and `ctrl_byte[7]` is always 1.
- R6: A transfer may carry a control pair, a frequency pair, or both, in either order. Every complete pair is applied.
- R7: When a transfer ends after three data bytes, the third byte is acknowledged and then dropped. No register changes because of it.
- R8: Data bytes from the fifth onward get no acknowledge and change no register.
- R9: A STOP or START that arrives after the first byte of a pair and before its second byte drops that partial pair.
- R10: A repeated START restarts address matching and sets the data byte count back to zero, so the next byte is again treated as an address.
- R11: An address byte whose read/write bit is 1 gets no acknowledge, and the bytes that follow it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus (wired-AND level) |
| addr_sel | input | 2 | Address strap, selects address bits [2:1] |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| freq_word | output | FREQ_W | Divider ratio register |
| ctrl_byte | output | 8 | Control register, bit 7 always 1 |
| band_bits | output | BAND_W | Band-switch register |
| freq_stb | output | 1 | One-cycle pulse when a frequency word is written |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 15-bit frequency word, a 4-bit band field and four usable data bytes. With these values every byte slot of a transfer can be reached: the two pair positions, the dropped third byte when the transfer ends after three bytes, and the unacknowledged bytes from the fifth onward. The random mix covers all four strap settings, foreign addresses, read addresses, odd byte counts and transfers chained by repeated START. Each of these is compared with a bench model of the register file and the strobe count.

// File: rtl/tune_rx_pkg.sv
package tune_rx_pkg;

    localparam logic [4:0] ADDR_STEM = 5'b11000;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_BITS,
        RX_ACK,
        RX_SKIP
    } rx_state_t;

    // A received data byte handed from the byte engine to the steering logic
    typedef struct packed {
        logic       vld;
        logic       odd;   // second byte of a pair
        logic [7:0] data;
    } rx_byte_t;

    function automatic logic [7:0] wr_addr(input logic [1:0] sel);
        return {ADDR_STEM, sel, 1'b0};
    endfunction

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic scl_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_q, sda_q;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_pin};
            sda_sh <= {sda_sh[STAGES-2:0], sda_pin};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/byte_engine.sv
module byte_engine
    import tune_rx_pkg::*;
#(
    parameter int MAX_DATA = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [1:0] addr_sel,
    output logic       sda_pull,
    output rx_byte_t   byte_o
);
    localparam int DW = $clog2(MAX_DATA + 1);

    rx_state_t       state;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg;
    logic            is_addr;
    logic [DW-1:0]   dcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            is_addr  <= 1'b0;
            dcnt     <= '0;
            sda_pull <= 1'b0;
            byte_o   <= '0;
        end else begin
            byte_o.vld <= 1'b0;
            if (start_det) begin
                state    <= RX_BITS;
                bitcnt   <= '0;
                is_addr  <= 1'b1;
                dcnt     <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= RX_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    RX_BITS: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (is_addr) begin
                                is_addr <= 1'b0;
                                dcnt    <= '0;
                                if (shreg == wr_addr(addr_sel)) begin
                                    sda_pull <= 1'b1;
                                    state    <= RX_ACK;
                                end else begin
                                    state <= RX_SKIP;
                                end
                            end else begin
                                state <= RX_ACK;
                                if (dcnt < DW'(MAX_DATA)) begin
                                    sda_pull <= 1'b1;
                                    byte_o   <= '{vld: 1'b1, odd: dcnt[0], data: shreg};
                                    dcnt     <= dcnt + 1'b1;
                                end
                            end
                        end
                    end
                    RX_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= RX_BITS;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/word_steer.sv
module word_steer
    import tune_rx_pkg::*;
#(
    parameter int          FREQ_W   = 15,
    parameter int          BAND_W   = 4,
    parameter int unsigned FREQ_RST = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_det,
    input  logic              stop_det,
    input  rx_byte_t          byte_i,
    output logic [FREQ_W-1:0] freq_word,
    output logic [7:0]        ctrl_byte,
    output logic [BAND_W-1:0] band_bits,
    output logic              freq_stb
);
    localparam int HI_W = FREQ_W - 8;

    logic [7:0] head;
    logic       head_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            head      <= '0;
            head_ok   <= 1'b0;
            freq_word <= FREQ_W'(FREQ_RST);
            ctrl_byte <= 8'h80;
            band_bits <= '0;
            freq_stb  <= 1'b0;
        end else begin
            freq_stb <= 1'b0;
            if (start_det || stop_det) begin
                head_ok <= 1'b0;
            end else if (byte_i.vld) begin
                if (!byte_i.odd) begin
                    head    <= byte_i.data;
                    head_ok <= 1'b1;
                end else if (head_ok) begin
                    head_ok <= 1'b0;
                    if (head[7]) begin
                        ctrl_byte <= head;
                        band_bits <= byte_i.data[BAND_W-1:0];
                    end else begin
                        freq_word <= {head[HI_W-1:0], byte_i.data};
                        freq_stb  <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tune_word_rx.sv
module tune_word_rx
    import tune_rx_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          FREQ_W      = 15,
    parameter int          BAND_W      = 4,
    parameter int unsigned FREQ_RST    = 256,
    parameter int          MAX_DATA    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel,
    output logic              sda_pull,
    output logic [FREQ_W-1:0] freq_word,
    output logic [7:0]        ctrl_byte,
    output logic [BAND_W-1:0] band_bits,
    output logic              freq_stb
);
    logic     scl_s, scl_rise, scl_fall, start_det, stop_det, sda_s;
    rx_byte_t rx_byte;
    logic     sda_unused;

    bus_sampler #(.STAGES(SYNC_STAGES)) u_samp (
        .clk       (clk),
        .rst       (rst),
        .scl_pin   (scl_i),
        .sda_pin   (sda_i),
        .scl_s     (scl_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Data line sampled through its own synchronizer chain inside the engine path
    bus_sampler #(.STAGES(SYNC_STAGES)) u_dsamp (
        .clk       (clk),
        .rst       (rst),
        .scl_pin   (sda_i),
        .sda_pin   (1'b1),
        .scl_s     (sda_s),
        .scl_rise  (sda_unused),
        .scl_fall  (),
        .start_det (),
        .stop_det  ()
    );

    byte_engine #(.MAX_DATA(MAX_DATA)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .sda_pull  (sda_pull),
        .byte_o    (rx_byte)
    );

    word_steer #(
        .FREQ_W   (FREQ_W),
        .BAND_W   (BAND_W),
        .FREQ_RST (FREQ_RST)
    ) u_steer (
        .clk       (clk),
        .rst       (rst),
        .start_det (start_det),
        .stop_det  (stop_det),
        .byte_i    (rx_byte),
        .freq_word (freq_word),
        .ctrl_byte (ctrl_byte),
        .band_bits (band_bits),
        .freq_stb  (freq_stb)
    );

endmodule

// File: rtl/tune_rx_chk.sv
module tune_rx_chk #(
    parameter int FREQ_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_pull,
    input logic [FREQ_W-1:0] freq_word,
    input logic [7:0]        ctrl_byte,
    input logic              freq_stb
);
    // R3
    ack_in_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_s);

    // R9
    stop_releases_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_pull);

    // R10
    start_releases_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_pull);

    // R4
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        freq_stb |=> !freq_stb);

    // R4
    freq_moves_on_stb_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(freq_word) |-> freq_stb);

    // R5
    ctrl_marker_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_byte[7]);

endmodule

bind tune_word_rx tune_rx_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull),
    .freq_word (freq_word),
    .ctrl_byte (ctrl_byte),
    .freq_stb  (freq_stb)
);

// File: tb/test_tune_word_rx.sv
`timescale 1ns/1ps
module test_tune_word_rx;

    localparam int H = 8;   // half bit period in clocks

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'd0;
    logic        sda_pull;
    logic [14:0] freq_word;
    logic [7:0]  ctrl_byte;
    logic [3:0]  band_bits;
    logic        freq_stb;
    wire         sda_line = sda_m & ~sda_pull;

    int          n_run = 0;
    int          n_fail = 0;
    int          stb_cnt = 0;
    int          exp_stb = 0;
    logic [14:0] exp_freq = 15'd256;
    logic [7:0]  exp_ctrl = 8'h80;
    logic [3:0]  exp_band = 4'd0;
    logic [7:0]  tx [8];
    bit          done = 1'b0;

    always #4 clk = ~clk;

    tune_word_rx i_tune_word_rx (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .addr_sel  (strap),
        .sda_pull  (sda_pull),
        .freq_word (freq_word),
        .ctrl_byte (ctrl_byte),
        .band_bits (band_bits),
        .freq_stb  (freq_stb)
    );

    always @(negedge clk) if (!rst && freq_stb) stb_cnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0; wait_clk(H);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(H);
            scl_m = 1'b1; wait_clk(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H / 2);
        acked = !sda_line;
        wait_clk(H / 2);
        scl_m = 1'b0;
    endtask

    function automatic void apply_pair(input logic [7:0] a, input logic [7:0] b);
        if (a[7]) begin
            exp_ctrl = a;
            exp_band = b[3:0];
        end else begin
            exp_freq = {a[6:0], b};
            exp_stb++;
        end
    endfunction

    task automatic check_regs(input string tag);
        wait_clk(6);
        chk(freq_word == exp_freq, tag, "freq_word", freq_word, exp_freq);
        chk(ctrl_byte == exp_ctrl, tag, "ctrl_byte", ctrl_byte, exp_ctrl);
        chk(band_bits == exp_band, tag, "band_bits", band_bits, exp_band);
        chk(stb_cnt == exp_stb, "R4", "strobe count", stb_cnt, exp_stb);
    endtask

    task automatic xfer(input logic [7:0] a, input int n, input bit do_stop,
                        input string tag);
        bit aok, got, exp;
        aok = (a == {5'b11000, strap, 1'b0});
        i2c_start;
        send_byte(a, got);
        chk(got == aok, a[0] ? "R11" : "R2", "address ack", got, aok);
        for (int i = 0; i < n; i++) begin
            exp = aok && (i < 4);
            if (aok) send_byte(tx[i], got);
            else     send_byte(tx[i], got);
            chk(got == exp, (i >= 4) ? "R8" : "R3", "data ack", got, exp);
            if (aok && i < 4 && i[0]) apply_pair(tx[i-1], tx[i]);
        end
        if (do_stop) i2c_stop;
        check_regs(tag);
    endtask

    initial begin
        wait_clk(200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset state
        chk(freq_word == 15'd256, "R1", "freq_word", freq_word, 256);
        chk(ctrl_byte == 8'h80, "R1", "ctrl_byte", ctrl_byte, 8'h80);
        chk(band_bits == 4'd0, "R1", "band_bits", band_bits, 0);
        chk(sda_pull == 1'b0, "R1", "sda_pull", sda_pull, 0);
        chk(freq_stb == 1'b0, "R1", "freq_stb", freq_stb, 0);

        // R6 frequency first, then control/band
        tx[0] = 8'h12; tx[1] = 8'h34; tx[2] = 8'hC5; tx[3] = 8'hF9;
        xfer(8'hC0, 4, 1'b1, "R6");
        // R6 control/band first, then frequency; band upper nibble ignored (R5)
        strap = 2'd3;
        tx[0] = 8'hAA; tx[1] = 8'h5C; tx[2] = 8'h7F; tx[3] = 8'hFF;
        xfer(8'hC6, 4, 1'b1, "R6");
        // R7 third byte dropped
        tx[0] = 8'h01; tx[1] = 8'h11; tx[2] = 8'h22;
        xfer(8'hC6, 3, 1'b1, "R7");
        // R8 fifth and sixth bytes ignored
        strap = 2'd1;
        tx[0] = 8'h81; tx[1] = 8'h03; tx[2] = 8'h40; tx[3] = 8'h00;
        tx[4] = 8'h00; tx[5] = 8'hFE;
        xfer(8'hC2, 6, 1'b1, "R8");
        // R2 foreign address
        tx[0] = 8'h05; tx[1] = 8'h55;
        xfer(8'hC4, 2, 1'b1, "R2");
        // R11 read bit set
        xfer(8'hC3, 2, 1'b1, "R11");
        // R9 partial pair abandoned by repeated START, R10 address matched again
        tx[0] = 8'h3F;
        xfer(8'hC2, 1, 1'b0, "R9");
        tx[0] = 8'hE0; tx[1] = 8'h0A;
        xfer(8'hC2, 2, 1'b0, "R10");
        tx[0] = 8'h00;
        xfer(8'hC2, 1, 1'b1, "R9");
        // R10 repeated START with foreign address right after a valid one
        tx[0] = 8'h22; tx[1] = 8'h33;
        xfer(8'hC2, 2, 1'b0, "R10");
        xfer(8'hC8, 2, 1'b1, "R10");

        // constrained random mix
        for (int t = 0; t < 60; t++) begin
            logic [7:0] a;
            int n;
            strap = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 5))
                0:       a = 8'($urandom);
                1:       a = {5'b11000, strap, 1'b1};
                default: a = {5'b11000, strap, 1'b0};
            endcase
            n = $urandom_range(0, 6);
            for (int k = 0; k < 8; k++) tx[k] = 8'($urandom);
            xfer(a, n, ($urandom_range(0, 3) != 0), "R6");
        end
        i2c_stop;
        check_regs("R9");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule